// File: doc/BRIEF.md
# Multiprocessor-Bit Serial Transmitter

This block is an asynchronous serial transmitter for a shared multidrop line on which one sender talks to several receivers. Every frame carries one extra bit after the data bits, in the slot a parity bit would use. A 1 in that bit marks the frame as an address frame that names a receiver. A 0 marks a data frame for the receiver named last. The sender takes the value of that bit from a control bit in its status register when each frame begins.

Software drives the block through a small register interface. It checks that the data-empty flag is 1, writes a byte into the data register, sets the multiprocessor control bit, and then clears the flag. When a frame starts, the transmitter copies the byte into its shift register and raises the flag again, so the next byte can be queued while the current one is still on the line. A second write path, used by a transfer agent that answers the empty-flag interrupt request, loads the data register and clears the flag in one step.

When the transmitter is disabled, the line holds a static level. That level is low when the break control bit is set. A programmable divider sets the length of each bit.

Top module: `mpb_uart_tx`

## Requirements
- R1: A frame is a start bit (0), then the data bits least significant first, then the multiprocessor bit, then the stop bits (1). Every bit lasts exactly baud_div+1 clock cycles.
- R2: The multiprocessor bit of a frame equals status bit 0 (register address 1) at the moment the frame starts. Software uses 1 for address frames and 0 for data frames.
- R3: Control register (address 2) bit 1 selects DATA_W-1 data bits, which drops the top data bit. Control bit 2 selects two stop bits. Together these give four formats.
- R4: Control bit 3 (parity enable) is stored but has no effect: no parity bit is sent and frame lengths do not change.
- R5: Status bit 7 is the data-empty flag and reads 1 after reset. A host write to the status register with bit 7 equal to 0 clears the flag. A write with bit 7 equal to 1 leaves it unchanged and starts no frame.
- R6: A frame starts when the transmitter is enabled, the flag is 0 and the shifter is idle. The flag returns to 1 at that start. The data register is copied at the start, so later writes to it do not change the frame in flight.
- R7: If the flag is 0 when the last stop bit ends, the next start bit follows with no idle cycle.
- R8: irq_empty equals the flag while the transmitter is enabled, and is 0 while it is disabled. A pulse on svc_wr loads svc_data into the data register and clears the flag.
- R9: Status bit 2 (transmit end) reads 0 after reset. It rises when the last stop bit ends with the flag at 1, and it clears when the next frame starts.
- R10: With control bit 0 (enable) at 1 and no frame in progress, txd is 1.
- R11: With the enable bit at 0, any frame in flight is aborted and no frame starts. txd is held at 0 when control bit 4 (break) is 1, and at 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Bit length minus one, in clock cycles |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the register selected by reg_addr (combinational) |
| svc_wr | input | 1 | Service write: loads the data register and clears the empty flag |
| svc_data | input | DATA_W | Data byte for a service write |
| irq_empty | output | 1 | Data-empty interrupt request |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that svc_wr pulses only while irq_empty is high and that the host clears the empty flag only after it has seen the flag at 1. Under those conditions a frame start never meets a clear in the same cycle. They also assume that baud_div changes only while the line is idle. The bench keeps to these conditions by construction. It queues a second byte only after the previous frame has started, it changes the divider only between frames, and it pulses the service write only after it has checked that the request is high.

// File: rtl/mpbt_pkg.sv
package mpbt_pkg;
   localparam int REG_W = 8;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   localparam int STAT_EMPTY = 7;
   localparam int STAT_END   = 2;
   localparam int STAT_MPB   = 0;

   localparam int CTRL_EN    = 0;
   localparam int CTRL_SHORT = 1;
   localparam int CTRL_TWO   = 2;
   localparam int CTRL_PAR   = 3;
   localparam int CTRL_BRK   = 4;

   typedef struct packed {
      logic short_data;
      logic two_stop;
   } fmt_t;
endpackage

// File: rtl/mpbt_baud_div.sv
module mpbt_baud_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/mpbt_regs.sv
module mpbt_regs
   import mpbt_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit SHORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] svc_data,
   input  logic              load,
   input  logic              end_set,
   output logic [DATA_W-1:0] data_q,
   output logic              empty_q,
   output logic              end_q,
   output logic              mpb_q,
   output logic              en_q,
   output logic              brk_q,
   output fmt_t              fmt
);
   logic wr_data, wr_stat, wr_ctrl;
   logic two_q, par_q, short_q;

   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (svc_wr)
         data_q <= svc_data;
      else if (wr_data)
         data_q <= reg_wdata[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         mpb_q   <= 1'b0;
      end else begin
         if (wr_stat)
            mpb_q <= reg_wdata[STAT_MPB];
         if (load)
            empty_q <= 1'b1;
         else if (svc_wr)
            empty_q <= 1'b0;
         else if (wr_stat && !reg_wdata[STAT_EMPTY])
            empty_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         end_q <= 1'b0;
      else if (load)
         end_q <= 1'b0;
      else if (end_set)
         end_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         two_q <= 1'b0;
         par_q <= 1'b0;
         brk_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q  <= reg_wdata[CTRL_EN];
         two_q <= reg_wdata[CTRL_TWO];
         par_q <= reg_wdata[CTRL_PAR];
         brk_q <= reg_wdata[CTRL_BRK];
      end
   end

   generate
      if (SHORT_EN) begin : g_short
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               short_q <= 1'b0;
            else if (wr_ctrl)
               short_q <= reg_wdata[CTRL_SHORT];
         end
      end else begin : g_no_short
         assign short_q = 1'b0;
      end
   endgenerate

   assign fmt.short_data = short_q;
   assign fmt.two_stop   = two_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_DATA: reg_rdata[DATA_W-1:0] = data_q;
         ADDR_STAT: begin
            reg_rdata[STAT_EMPTY] = empty_q;
            reg_rdata[STAT_END]   = end_q;
            reg_rdata[STAT_MPB]   = mpb_q;
         end
         ADDR_CTRL: begin
            reg_rdata[CTRL_EN]    = en_q;
            reg_rdata[CTRL_SHORT] = short_q;
            reg_rdata[CTRL_TWO]   = two_q;
            reg_rdata[CTRL_PAR]   = par_q;
            reg_rdata[CTRL_BRK]   = brk_q;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mpbt_shifter.sv
module mpbt_shifter
   import mpbt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              empty,
   input  logic [DATA_W-1:0] data,
   input  logic              mpb,
   input  fmt_t              fmt,
   input  logic              tick,
   output logic              load,
   output logic              end_set,
   output logic              busy,
   output logic              bit_out
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] frame, sr_q;
   logic [CNT_W-1:0]   nd, len, left_q;
   logic               last;

   assign nd  = fmt.short_data ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
   assign len = CNT_W'(2) + nd + (fmt.two_stop ? CNT_W'(2) : CNT_W'(1));

   // start bit, data slots, multiprocessor slot, stop fill
   generate
      for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
         if (i == 0) begin : g_start
            assign frame[i] = 1'b0;
         end else if (i <= DATA_W) begin : g_data
            assign frame[i] = (CNT_W'(i) <= nd) ? data[i-1] :
                              (CNT_W'(i) == nd + CNT_W'(1)) ? mpb : 1'b1;
         end else begin : g_tail
            assign frame[i] = (CNT_W'(i) == nd + CNT_W'(1)) ? mpb : 1'b1;
         end
      end
   endgenerate

   assign last    = busy && tick && (left_q == CNT_W'(1));
   assign load    = tx_en && !empty && (!busy || last);
   assign end_set = tx_en && last && !load;
   assign bit_out = sr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sr_q   <= '1;
         left_q <= '0;
      end else if (!tx_en) begin
         busy   <= 1'b0;
         sr_q   <= '1;
         left_q <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         sr_q   <= frame;
         left_q <= len;
      end else if (busy && tick) begin
         sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
         left_q <= left_q - CNT_W'(1);
         if (left_q == CNT_W'(1))
            busy <= 1'b0;
      end
   end
endmodule

// File: rtl/mpb_uart_tx.sv
module mpb_uart_tx
   import mpbt_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 16,
   parameter bit SHORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] svc_data,
   output logic              irq_empty,
   output logic              txd
);
   generate
      if (DATA_W < 5 || DATA_W > REG_W) begin : g_bad_data_w
         $error("mpb_uart_tx: DATA_W must lie in 5..8");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div_w
         $error("mpb_uart_tx: DIV_W must lie in 1..32");
      end
   endgenerate

   logic [DATA_W-1:0] data_q;
   logic              tdre, tend, mpb, tx_en, brk;
   logic              load, end_set, busy, bit_out, tick;
   fmt_t              fmt;

   mpbt_regs #(.DATA_W(DATA_W), .SHORT_EN(SHORT_EN)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .svc_wr    (svc_wr),
      .svc_data  (svc_data),
      .load      (load),
      .end_set   (end_set),
      .data_q    (data_q),
      .empty_q   (tdre),
      .end_q     (tend),
      .mpb_q     (mpb),
      .en_q      (tx_en),
      .brk_q     (brk),
      .fmt       (fmt)
   );

   mpbt_baud_div #(.DIV_W(DIV_W)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load || !busy),
      .div   (baud_div),
      .tick  (tick)
   );

   mpbt_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .empty   (tdre),
      .data    (data_q),
      .mpb     (mpb),
      .fmt     (fmt),
      .tick    (tick),
      .load    (load),
      .end_set (end_set),
      .busy    (busy),
      .bit_out (bit_out)
   );

   assign irq_empty = tdre && tx_en;
   assign txd       = !tx_en ? !brk : (busy ? bit_out : 1'b1);
endmodule

// File: rtl/mpbt_checker.sv
module mpbt_checker (
   input logic clk,
   input logic rst_n,
   input logic txd,
   input logic tx_en,
   input logic brk,
   input logic busy,
   input logic load,
   input logic tdre,
   input logic tend,
   input logic svc_wr,
   input logic irq_empty
);
   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !busy) |-> txd);

   p_break_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && brk) |-> !txd);

   p_empty_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> tdre);

   p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!tx_en || !txd));

   p_svc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && !load) |=> !tdre);

   p_end_with_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend) |-> tdre);

   p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty |-> (tdre && tx_en));
endmodule

bind mpb_uart_tx mpbt_checker i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .txd       (txd),
   .tx_en     (tx_en),
   .brk       (brk),
   .busy      (busy),
   .load      (load),
   .tdre      (tdre),
   .tend      (tend),
   .svc_wr    (svc_wr),
   .irq_empty (irq_empty)
);

// File: tb/test_mpb_uart_tx.sv
module test_mpb_uart_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] baud_div = 16'd3;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        svc_wr = 1'b0;
   logic [7:0]  svc_data = 8'd0;
   logic        irq_empty;
   logic        txd;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int cur_p = 4;
   bit cur_short = 0;
   bit cur_two = 0;
   bit mon_on = 0;
   bit mon_busy = 0;
   logic [15:0] q_bits[$];
   int          q_len[$];
   int          starts[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mpb_uart_tx i_mpb_uart_tx (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .svc_wr(svc_wr), .svc_data(svc_data), .irq_empty(irq_empty), .txd(txd)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wctrl(input logic [7:0] v);
      cur_short = v[1];
      cur_two = v[2];
      wreg(2'd2, v);
   endtask

   // expected frame from the requirement text (R1, R3)
   task automatic push_exp(input logic [7:0] d, input bit mpb);
      logic [15:0] b;
      int nd;
      nd = cur_short ? 7 : 8;
      b = '1;
      b[0] = 1'b0;
      for (int i = 0; i < nd; i++) b[1+i] = d[i];
      b[nd+1] = mpb;
      q_bits.push_back(b);
      q_len.push_back(nd + 2 + (cur_two ? 2 : 1));
   endtask

   task automatic send(input logic [7:0] d, input bit mpb);
      push_exp(d, mpb);
      wreg(2'd0, d);
      wreg(2'd1, {7'd0, mpb});
   endtask

   task automatic wait_idle();
      bit done = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (q_bits.size() == 0 && !mon_busy) begin done = 1; break; end
      end
      chk(done, "R6 frame completion", int'(done), 1);
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops expected frames and compares every cycle of every bit
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && rst_n && txd === 1'b0) begin
            mon_busy = 1;
            starts.push_back(cyc);
            if (q_bits.size() == 0) begin
               chk(0, "R5/R6 unexpected frame", 0, 1);
               while (txd === 1'b0) @(negedge clk);
            end else begin
               logic [15:0] b;
               int n;
               b = q_bits.pop_front();
               n = q_len.pop_front();
               for (int k = 0; k < n; k++) begin
                  bit ok = 1;
                  logic seen = b[k];
                  for (int c = 0; c < cur_p; c++) begin
                     if (k != 0 || c != 0) @(negedge clk);
                     if (txd !== b[k]) begin ok = 0; seen = txd; end
                  end
                  chk(ok, $sformatf("R1/R2/R3 frame bit %0d", k), int'(seen), int'(b[k]));
               end
            end
            mon_busy = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk(txd === 1'b1, "R11 reset line high", int'(txd), 1);
      rreg(2'd1, r);
      chk(r == 8'h80, "R5/R9 reset status", r, 8'h80);
      chk(irq_empty === 1'b0, "R8 no request while disabled", int'(irq_empty), 0);

      wctrl(8'h01);
      chk(txd === 1'b1, "R10 idle high", int'(txd), 1);
      chk(irq_empty === 1'b1, "R8 request while empty", int'(irq_empty), 1);
      mon_on = 1;

      // address frame then data frame
      send(8'h01, 1'b1);
      repeat (3) @(negedge clk);
      rreg(2'd1, r);
      chk(r == 8'h81, "R6/R9 flag back at start, end low", r, 8'h81);
      wait_idle();
      rreg(2'd1, r);
      chk(r == 8'h85, "R9 end flag after last stop", r, 8'h85);
      send(8'hAA, 1'b0);
      wait_idle();

      // back to back, data register rewritten during frame
      starts.delete();
      send(8'h55, 1'b1);
      repeat (4) @(negedge clk);
      send(8'h0F, 1'b0);
      wait_idle();
      chk(starts.size() == 2 && starts[1] - starts[0] == 44, "R7 no idle gap",
          starts.size() == 2 ? starts[1] - starts[0] : -1, 44);

      // formats
      wctrl(8'h07);
      send(8'hFF, 1'b0);
      wait_idle();
      wctrl(8'h05);
      send(8'h80, 1'b1);
      wait_idle();
      wctrl(8'h03);
      send(8'hC1, 1'b1);
      wait_idle();

      // parity enable ignored
      wctrl(8'h09);
      starts.delete();
      send(8'h03, 1'b0);
      repeat (4) @(negedge clk);
      send(8'h01, 1'b0);
      wait_idle();
      chk(starts.size() == 2 && starts[1] - starts[0] == 44, "R4 frame length unchanged",
          starts.size() == 2 ? starts[1] - starts[0] : -1, 44);

      // other bit lengths
      wctrl(8'h01);
      baud_div = 16'd0; cur_p = 1;
      send(8'hC3, 1'b1);
      wait_idle();
      baud_div = 16'd6; cur_p = 7;
      send(8'h5A, 1'b0);
      wait_idle();
      baud_div = 16'd3; cur_p = 4;

      // status write with bit 7 set leaves flag
      wreg(2'd1, 8'h80);
      repeat (20) @(negedge clk);
      chk(txd === 1'b1, "R5 no frame on bit7 write", int'(txd), 1);
      rreg(2'd1, r);
      chk(r[7] == 1'b1, "R5 flag kept", r[7], 1);

      // service path
      push_exp(8'h3C, 1'b0);
      chk(irq_empty === 1'b1, "R8 request before service", int'(irq_empty), 1);
      @(negedge clk);
      svc_wr = 1'b1; svc_data = 8'h3C;
      @(negedge clk);
      svc_wr = 1'b0;
      chk(irq_empty === 1'b0, "R8 service clears flag", int'(irq_empty), 0);
      @(negedge clk);
      chk(irq_empty === 1'b1, "R6 flag set at start", int'(irq_empty), 1);
      wait_idle();

      // disabled: pending byte waits
      wctrl(8'h00);
      wreg(2'd0, 8'h99);
      wreg(2'd1, 8'h01);
      repeat (20) @(negedge clk);
      chk(txd === 1'b1, "R11 no frame while disabled", int'(txd), 1);
      rreg(2'd1, r);
      chk(r == 8'h05, "R11 flag stays clear while disabled", r, 8'h05);
      push_exp(8'h99, 1'b1);
      wctrl(8'h01);
      wait_idle();

      // abort and break
      mon_on = 0;
      wreg(2'd0, 8'h00);
      wreg(2'd1, 8'h00);
      repeat (3) @(negedge clk);
      chk(txd === 1'b0, "R1 start bit low", int'(txd), 0);
      wctrl(8'h10);
      chk(txd === 1'b0, "R11 break low", int'(txd), 0);
      chk(irq_empty === 1'b0, "R8 no request while disabled", int'(irq_empty), 0);
      repeat (10) @(negedge clk);
      chk(txd === 1'b0, "R11 break held", int'(txd), 0);
      wctrl(8'h00);
      chk(txd === 1'b1, "R11 disabled high", int'(txd), 1);
      wctrl(8'h01);
      repeat (8) @(negedge clk);
      chk(txd === 1'b1, "R10 idle after abort", int'(txd), 1);
      rreg(2'd1, r);
      chk(r == 8'h80, "R11 aborted frame leaves nothing pending", r, 8'h80);

      mon_on = 1;
      send(8'h77, 1'b1);
      wait_idle();

      summary();
      $finish;
   end
endmodule